// File: doc/BRIEF.md
# Branch Target Address Generator

This block forms the next program counter for a small 8-bit controller once an instruction has been decoded. It is given the address and byte length of the current instruction, a code for the way the target is formed, and every operand a target may be built from: an 8-bit signed displacement, an 11-bit in-page address, a full 16-bit address, the accumulator and the 16-bit data pointer. From these it produces one 16-bit next-PC value.

The first step of every target is the sequential address: the current PC plus the instruction length. A displacement is added to that value, and an in-page target keeps its page bits. A separate take input decides whether a conditional displacement branch is applied. Branch conditions are evaluated elsewhere.

Each request is a single-cycle strobe. The result is registered and appears on the next clock together with a valid flag. The result then holds until the next request.

Top module: `jump_target_gen`

## Requirements
- R1: While rst is high and on the first cycle after it, outValid is 0 and nextPc is 0000h.
- R2: outValid is 1 exactly on the cycle after a cycle with inValid high, and nextPc changes only on that cycle. Without a request, nextPc keeps its value.
- R3: With kind code 0 (sequential), nextPc = curPc + instLen modulo 2^16. An instLen code of 0 is treated as length 1.
- R4: With kind code 1 (relative) and take = 1, nextPc = curPc + instLen + relOfs modulo 2^16, where relOfs is sign-extended (range -128 to +127).
- R5: With kind code 1 and take = 0, nextPc = curPc + instLen.
- R6: With kind code 2 (in-page), nextPc[15:11] equals bits 15:11 of curPc + instLen, and nextPc[10:0] = pageAddr. The page bits are therefore taken after the PC has advanced, even when that advance crosses a 2 KB boundary.
- R7: With kind code 3 (long), nextPc = longAddr.
- R8: With kind code 4 (indexed), nextPc = dptrVal + accVal modulo 2^16, where accVal is zero-extended.
- R9: take has no effect for kind codes 0, 2, 3 and 4.
- R10: Kind codes 5 to 7 behave as sequential (kind code 0), whatever the value of take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe: one target computation |
| kind | input | 3 | Target form: 0 seq, 1 rel, 2 in-page, 3 long, 4 indexed |
| instLen | input | 2 | Instruction length in bytes (1..3; 0 treated as 1) |
| curPc | input | 16 | Address of the current instruction |
| relOfs | input | 8 | Signed displacement |
| pageAddr | input | 11 | In-page target address |
| longAddr | input | 16 | Full target address |
| accVal | input | 8 | Accumulator (unsigned index) |
| dptrVal | input | 16 | Data pointer (base address) |
| take | input | 1 | Apply a relative branch |
| outValid | output | 1 | nextPc updated this cycle |
| nextPc | output | 16 | Computed next program counter |

## Verification
The bench checks that the displacement is added to the advanced PC and not to curPc. A design that got this wrong would miss each target by the instruction length, so the 0100h/+5 case would give 0105h instead of 0107h.

It checks negative displacements and wraps past FFFFh. Zero-extending the displacement would turn a backward jump into a jump forward by almost 256 bytes, and a missing wrap would show up as a wrong upper byte.

It takes an in-page jump from 07FEh to show that the page bits come from the advanced PC. A design that used the old page would land in page 0 instead of page 1. It also adds FFh to a data pointer near the top of memory, which exposes an accumulator that was wrongly sign-extended.

// File: rtl/jt_pkg.sv
package jt_pkg;

  typedef enum logic [2:0] {
    JK_SEQ  = 3'd0,
    JK_REL  = 3'd1,
    JK_ABS  = 3'd2,
    JK_LONG = 3'd3,
    JK_IDX  = 3'd4
  } jumpKind_e;

  // Strobes from control to datapath; all selects low means sequential.
  typedef struct packed {
    logic load;
    logic selRel;
    logic selAbs;
    logic selLong;
    logic selIdx;
  } jtStrobe_t;

endpackage

// File: rtl/jt_ctrl.sv
module jt_ctrl
  import jt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [2:0] kind,
  input  logic       take,
  output jtStrobe_t  strobe
);

  always_comb begin
    strobe      = '0;
    strobe.load = inValid;
    unique case (kind)
      JK_REL:  strobe.selRel  = take;
      JK_ABS:  strobe.selAbs  = 1'b1;
      JK_LONG: strobe.selLong = 1'b1;
      JK_IDX:  strobe.selIdx  = 1'b1;
      default: ;
    endcase
  end

  // R5: an untaken relative branch falls through to sequential
  a_r5_untaken_is_seq: assert property (@(posedge clk) disable iff (rst)
    (kind == JK_REL && !take) |-> !(strobe.selRel | strobe.selAbs | strobe.selLong | strobe.selIdx));

  // R10: unused kind codes select nothing (sequential)
  a_r10_unused_kind_seq: assert property (@(posedge clk) disable iff (rst)
    (kind > JK_IDX) |-> (strobe[3:0] == 4'b0000));

  // R9: take never changes the select for a non-relative kind
  a_r9_take_no_effect: assert property (@(posedge clk) disable iff (rst)
    (kind != JK_REL) |-> !strobe.selRel);

endmodule

// File: rtl/jt_datapath.sv
module jt_datapath
  import jt_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int OFS_W  = 8,
  parameter int PAGE_W = 11,
  parameter int LEN_W  = 2,
  parameter int ACC_W  = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  jtStrobe_t         strobe,
  input  logic [LEN_W-1:0]  instLen,
  input  logic [PC_W-1:0]   curPc,
  input  logic [OFS_W-1:0]  relOfs,
  input  logic [PAGE_W-1:0] pageAddr,
  input  logic [PC_W-1:0]   longAddr,
  input  logic [ACC_W-1:0]  accVal,
  input  logic [PC_W-1:0]   dptrVal,
  output logic              outValid,
  output logic [PC_W-1:0]   nextPc
);

  localparam int HIGH_W = PC_W - PAGE_W;
  localparam int EXT_W  = PC_W - OFS_W;

  logic [LEN_W-1:0] lenEff;
  logic [PC_W-1:0]  seqPc;
  logic [PC_W-1:0]  ofsExt;
  logic [PC_W-1:0]  relPc;
  logic [PC_W-1:0]  absPc;
  logic [PC_W-1:0]  idxPc;
  logic [PC_W-1:0]  pcMux;

  assign lenEff = (instLen == '0) ? LEN_W'(1) : instLen;
  assign seqPc  = curPc + PC_W'(lenEff);
  assign ofsExt = {{EXT_W{relOfs[OFS_W-1]}}, relOfs};
  assign relPc  = seqPc + ofsExt;
  assign absPc  = {seqPc[PC_W-1:PAGE_W], pageAddr};
  assign idxPc  = dptrVal + PC_W'(accVal);

  always_comb begin
    pcMux = seqPc;
    if (strobe.selRel)  pcMux = relPc;
    if (strobe.selAbs)  pcMux = absPc;
    if (strobe.selLong) pcMux = longAddr;
    if (strobe.selIdx)  pcMux = idxPc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      nextPc   <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) nextPc <= pcMux;
    end
  end

  // Control must never pick two target forms at once
  a_r2_single_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.selRel, strobe.selAbs, strobe.selLong, strobe.selIdx}));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> outValid);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> ($stable(nextPc) && !outValid));

  a_r7_long_target: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.selLong) |=> (nextPc == $past(longAddr)));

  a_r6_page_from_advanced: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.selAbs) |=>
      (nextPc[PC_W-1:PAGE_W] == $past(seqPc[PC_W-1:PAGE_W]) &&
       nextPc[PAGE_W-1:0]    == $past(pageAddr)));

  // R1: right after reset the output is cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    $fell(rst) |-> (!outValid && nextPc == '0));

  // Length is never added as zero
  a_r3_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    lenEff != '0);

endmodule

// File: rtl/jump_target_gen.sv
module jump_target_gen
  import jt_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int OFS_W  = 8,
  parameter int PAGE_W = 11,
  parameter int LEN_W  = 2,
  parameter int ACC_W  = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [2:0]        kind,
  input  logic [LEN_W-1:0]  instLen,
  input  logic [PC_W-1:0]   curPc,
  input  logic [OFS_W-1:0]  relOfs,
  input  logic [PAGE_W-1:0] pageAddr,
  input  logic [PC_W-1:0]   longAddr,
  input  logic [ACC_W-1:0]  accVal,
  input  logic [PC_W-1:0]   dptrVal,
  input  logic              take,
  output logic              outValid,
  output logic [PC_W-1:0]   nextPc
);

  jtStrobe_t strobe;

  jt_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .kind    (kind),
    .take    (take),
    .strobe  (strobe)
  );

  jt_datapath #(
    .PC_W   (PC_W),
    .OFS_W  (OFS_W),
    .PAGE_W (PAGE_W),
    .LEN_W  (LEN_W),
    .ACC_W  (ACC_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .instLen  (instLen),
    .curPc    (curPc),
    .relOfs   (relOfs),
    .pageAddr (pageAddr),
    .longAddr (longAddr),
    .accVal   (accVal),
    .dptrVal  (dptrVal),
    .outValid (outValid),
    .nextPc   (nextPc)
  );

endmodule

// File: tb/jump_target_gen_tb.sv
module jump_target_gen_tb;

  typedef struct packed {
    logic [2:0]  kind;
    logic [1:0]  len;
    logic [15:0] pc;
    logic [7:0]  ofs;
    logic [10:0] page;
    logic [15:0] lng;
    logic [7:0]  acc;
    logic [15:0] dptr;
    logic        take;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd1, 16'h1234, 8'h00, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h1235, 4'd3},  // R3
    '{3'd0, 2'd3, 16'hFFFF, 8'h00, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0002, 4'd3},  // R3 wrap
    '{3'd0, 2'd0, 16'h0010, 8'h00, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0011, 4'd3},  // R3 len 0
    '{3'd1, 2'd2, 16'h0100, 8'h05, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h0107, 4'd4},  // R4
    '{3'd1, 2'd2, 16'h0100, 8'hFE, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h0100, 4'd4},  // R4 back
    '{3'd1, 2'd3, 16'h0200, 8'h80, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h0183, 4'd4},  // R4 -128
    '{3'd1, 2'd2, 16'hFFFE, 8'h7F, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h007F, 4'd4},  // R4 wrap
    '{3'd1, 2'd2, 16'h0100, 8'h05, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0102, 4'd5},  // R5
    '{3'd2, 2'd2, 16'h1234, 8'h00, 11'h5A5, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h15A5, 4'd6},  // R6
    '{3'd2, 2'd2, 16'h07FE, 8'h00, 11'h001, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0801, 4'd6},  // R6 crossing
    '{3'd2, 2'd2, 16'hFFFE, 8'h00, 11'h7FF, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h07FF, 4'd6},  // R6 wrap
    '{3'd3, 2'd3, 16'h0100, 8'h00, 11'h000, 16'hBEEF, 8'h00, 16'h0000, 1'b1, 16'hBEEF, 4'd7},  // R7
    '{3'd4, 2'd1, 16'h0300, 8'h00, 11'h000, 16'h0000, 8'h10, 16'h2000, 1'b0, 16'h2010, 4'd8},  // R8
    '{3'd4, 2'd1, 16'h0300, 8'h00, 11'h000, 16'h0000, 8'hFF, 16'hFFF0, 1'b0, 16'h00EF, 4'd8},  // R8 wrap
    '{3'd3, 2'd3, 16'h0100, 8'h00, 11'h000, 16'h4321, 8'h00, 16'h0000, 1'b0, 16'h4321, 4'd9},  // R9
    '{3'd4, 2'd1, 16'h0300, 8'h00, 11'h000, 16'h0000, 8'h01, 16'h1000, 1'b1, 16'h1001, 4'd9},  // R9
    '{3'd5, 2'd2, 16'h0040, 8'h10, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h0042, 4'd10}, // R10
    '{3'd7, 2'd1, 16'h0040, 8'h10, 11'h000, 16'h9999, 8'h00, 16'h0000, 1'b0, 16'h0041, 4'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [2:0]  kind = '0;
  logic [1:0]  instLen = '0;
  logic [15:0] curPc = '0;
  logic [7:0]  relOfs = '0;
  logic [10:0] pageAddr = '0;
  logic [15:0] longAddr = '0;
  logic [7:0]  accVal = '0;
  logic [15:0] dptrVal = '0;
  logic        take = 1'b0;
  logic        outValid;
  logic [15:0] nextPc;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  jump_target_gen u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .kind(kind), .instLen(instLen),
    .curPc(curPc), .relOfs(relOfs), .pageAddr(pageAddr), .longAddr(longAddr),
    .accVal(accVal), .dptrVal(dptrVal), .take(take),
    .outValid(outValid), .nextPc(nextPc)
  );

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    kind = v.kind; instLen = v.len; curPc = v.pc; relOfs = v.ofs;
    pageAddr = v.page; longAddr = v.lng; accVal = v.acc; dptrVal = v.dptr;
    take = v.take;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset", {outValid, nextPc}, 17'h0_0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {outValid, nextPc}, 17'h0_0000);

    for (int i = 0; i < NV; i++) begin
      load(VECS[i]);
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      check($sformatf("R%0d vector %0d", VECS[i].req, i), {outValid, nextPc}, {1'b1, VECS[i].exp});
    end

    // R2: inputs change without a request, output holds and valid drops
    load(VECS[11]);
    @(negedge clk);
    check("R2 hold", {outValid, nextPc}, {1'b0, VECS[NV-1].exp});
    @(negedge clk);
    check("R2 idle", {outValid, nextPc}, {1'b0, VECS[NV-1].exp});

    // R2: back-to-back requests, each result the cycle after its request
    load(VECS[3]);
    inValid = 1'b1;
    @(negedge clk);
    check("R2 burst first", {outValid, nextPc}, {1'b1, 16'h0107});
    load(VECS[12]);
    @(negedge clk);
    inValid = 1'b0;
    check("R2 burst second", {outValid, nextPc}, {1'b1, 16'h2010});

    // R1: reset in mid-run clears the output
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset", {outValid, nextPc}, 17'h0_0000);

    finished = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !finished; c++) @(negedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule